// File: doc/BRIEF.md
# Accumulator ALU with Flags

This unit is the arithmetic and logic stage of a small accumulator machine. Each accepted command carries a 4-bit opcode and an 8-bit operand. The unit combines the operand with the accumulator it holds and works out the next accumulator value, the next carry flag and the next zero flag. Every operation changes only the state it is defined to touch. The rotates use the carry flag as a ninth bit, so a chain of rotates moves bits through the carry. Compare sets the flags and leaves the accumulator alone.

Commands arrive on a valid/ready interface. `op_ready` is low during reset and high from the first clock edge after reset is released. The unit never applies back-pressure after that point: every cycle with `op_valid` high consumes one command. A producer may hold `op_valid` high for back-to-back commands. The command is executed at the edge where `op_valid && op_ready`. The combinational `res_*` outputs show the pending update in the accepting cycle, and the registered `acc_q`, `c_q` and `z_q` outputs show it one cycle later. The third flag is the external data flag. It is held outside this unit, and `res_d_clr` tells its owner to clear it.

Top module: `acc_alu_core`

## Requirements
- R1: While `rst_n` is low, `acc_q`, `c_q`, `z_q` and `op_ready` are 0. `op_ready` is 1 from the first rising edge after reset is released.
- R2: Opcode 0x5 (bitwise AND) and opcode 0x6 (bitwise OR) load `acc_q & operand` or `acc_q | operand` into the accumulator and set `z_q` when that value is 0. `c_q` is unchanged.
- R3: Opcode 0x7 (add) loads `(acc_q + operand) mod 256`. `c_q` takes the ninth bit of the sum, and `z_q` is set when the stored value is 0.
- R4: Opcode 0x8 (subtract) loads `(acc_q - operand) mod 256`. `c_q` is set when `operand > acc_q` as unsigned values (a borrow), and `z_q` is set when the stored value is 0.
- R5: Opcode 0xA (compare) updates `c_q` and `z_q` exactly as subtract would. The accumulator is unchanged and `res_acc_we` stays 0.
- R6: Opcode 0xD (rotate left) loads `{acc_q[6:0], c_q}` and moves the old `acc_q[7]` into `c_q`. `z_q` is unchanged.
- R7: Opcode 0xE (rotate right) loads `{c_q, acc_q[7:1]}` and moves the old `acc_q[0]` into `c_q`. `z_q` is unchanged.
- R8: Opcode 0xF (clear flags) clears `c_q` and `z_q` and leaves the accumulator unchanged. `res_d_clr` is 1 in the accepting cycle and 0 in every other cycle.
- R9: The other opcodes (0x0–0x4, 0x9, 0xB, 0xC), and any cycle without an accepted command, leave `acc_q`, `c_q` and `z_q` unchanged and hold all `res_*` write enables at 0.
- R10: The registered state after an accepted command equals what the `res_*` outputs showed for the state bits whose write enables were 1 in the accepting cycle. The update is visible one clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Command present |
| op_ready | output | 1 | Unit accepts a command this cycle |
| op_code | input | 4 | Operation selector |
| operand | input | 8 | Immediate operand |
| res_acc | output | 8 | Next accumulator value |
| res_acc_we | output | 1 | Accumulator will be written |
| res_c | output | 1 | Next carry flag |
| res_c_we | output | 1 | Carry flag will be written |
| res_z | output | 1 | Next zero flag |
| res_z_we | output | 1 | Zero flag will be written |
| res_d_clr | output | 1 | Clear request for the external data flag |
| acc_q | output | 8 | Accumulator register |
| c_q | output | 1 | Carry flag register |
| z_q | output | 1 | Zero flag register |

## Verification
Carry and zero can both change in the same cycle when an add wraps to exactly zero, for example 0x80 + 0x80 or 0xFF + 0x01. A subtract of equal values produces zero with no borrow. The sweep sets accumulator and carry to every combination on a grid, then issues each opcode with operands on the same grid. Directed wrap cases cover the points the grid misses. The bench keeps its own accumulator and flags, computed arithmetically, and after every command it compares both flags and the accumulator against them. A wrong priority or a flag update that is dropped in the shared cycle therefore shows up as a mismatch.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_AND = 4'h5;
  localparam logic [OPC_W-1:0] OPC_OR  = 4'h6;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'h7;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'h8;
  localparam logic [OPC_W-1:0] OPC_CMP = 4'hA;
  localparam logic [OPC_W-1:0] OPC_ROL = 4'hD;
  localparam logic [OPC_W-1:0] OPC_ROR = 4'hE;
  localparam logic [OPC_W-1:0] OPC_CLF = 4'hF;
endpackage

// File: rtl/acc_alu_bitwise.sv
module acc_alu_bitwise #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_or,
  output logic [W-1:0] y
);
  assign y = sel_or ? (a | b) : (a & b);
endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         cout
);
  logic [W:0] ext;
  // For subtraction the top bit of the extended difference is the borrow.
  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b};
    else     ext = {1'b0, a} + {1'b0, b};
  end
  assign y    = ext[W-1:0];
  assign cout = ext[W];
endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         left,
  output logic [W-1:0] y,
  output logic         cout
);
  logic [W-1:0] rl, rr;
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign rl[i] = cin;
      assign rr[i] = a[i+1];
    end else if (i == W-1) begin : g_hi
      assign rl[i] = a[i-1];
      assign rr[i] = cin;
    end else begin : g_mid
      assign rl[i] = a[i-1];
      assign rr[i] = a[i+1];
    end
  end
  assign y    = left ? rl : rr;
  assign cout = left ? a[W-1] : a[0];
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [OPC_W-1:0] op_code,
  input  logic [W-1:0]     operand,
  output logic [W-1:0]     res_acc,
  output logic             res_acc_we,
  output logic             res_c,
  output logic             res_c_we,
  output logic             res_z,
  output logic             res_z_we,
  output logic             res_d_clr,
  output logic [W-1:0]     acc_q,
  output logic             c_q,
  output logic             z_q
);
  logic         accept;
  logic [W-1:0] bw_y, as_y, rt_y, pick;
  logic         as_c, rt_c, clr;

  assign accept = op_valid & op_ready;

  acc_alu_bitwise #(.W(W)) u_bitwise (
    .a(acc_q), .b(operand), .sel_or(op_code == OPC_OR), .y(bw_y)
  );

  acc_alu_addsub #(.W(W)) u_addsub (
    .a(acc_q), .b(operand), .sub(op_code != OPC_ADD), .y(as_y), .cout(as_c)
  );

  acc_alu_rotate #(.W(W)) u_rotate (
    .a(acc_q), .cin(c_q), .left(op_code == OPC_ROL), .y(rt_y), .cout(rt_c)
  );

  always_comb begin
    pick       = acc_q;
    res_acc_we = 1'b0;
    res_c      = c_q;
    res_c_we   = 1'b0;
    res_z_we   = 1'b0;
    clr        = 1'b0;
    if (accept) begin
      case (op_code)
        OPC_AND, OPC_OR: begin
          pick       = bw_y;
          res_acc_we = 1'b1;
          res_z_we   = 1'b1;
        end
        OPC_ADD, OPC_SUB: begin
          pick       = as_y;
          res_acc_we = 1'b1;
          res_c      = as_c;
          res_c_we   = 1'b1;
          res_z_we   = 1'b1;
        end
        OPC_CMP: begin
          pick     = as_y;
          res_c    = as_c;
          res_c_we = 1'b1;
          res_z_we = 1'b1;
        end
        OPC_ROL, OPC_ROR: begin
          pick       = rt_y;
          res_acc_we = 1'b1;
          res_c      = rt_c;
          res_c_we   = 1'b1;
        end
        OPC_CLF: begin
          res_c    = 1'b0;
          res_c_we = 1'b1;
          res_z_we = 1'b1;
          clr      = 1'b1;
        end
        default: ;
      endcase
    end
    res_acc   = pick;
    res_z     = clr ? 1'b0 : (res_z_we ? ~|pick : z_q);
    res_d_clr = clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_ready <= 1'b0;
      acc_q    <= '0;
      c_q      <= 1'b0;
      z_q      <= 1'b0;
    end else begin
      op_ready <= 1'b1;
      if (res_acc_we) acc_q <= res_acc;
      if (res_c_we)   c_q   <= res_c;
      if (res_z_we)   z_q   <= res_z;
    end
  end
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic [OPC_W-1:0] op_code,
  input logic [W-1:0]     operand,
  input logic [W-1:0]     acc_q,
  input logic             c_q,
  input logic             z_q,
  input logic             res_d_clr
);
  logic acc_ok;
  assign acc_ok = op_valid && op_ready;

  AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && (op_code == OPC_AND || op_code == OPC_OR) |=> (c_q == $past(c_q)) && (z_q == (acc_q == '0))); // R2
  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && op_code == OPC_ADD |=> ({c_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(operand)})) && (z_q == (acc_q == '0))); // R3
  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && op_code == OPC_SUB |=> (c_q == ($past(operand) > $past(acc_q))) && (z_q == (acc_q == '0))); // R4
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && op_code == OPC_CMP |=> $stable(acc_q) && (z_q == (acc_q == $past(operand)))); // R5
  AST_ROL_THROUGH_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && op_code == OPC_ROL |=> (acc_q == {$past(acc_q[W-2:0]), $past(c_q)}) && (c_q == $past(acc_q[W-1])) && $stable(z_q)); // R6
  AST_ROR_THROUGH_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && op_code == OPC_ROR |=> (acc_q == {$past(c_q), $past(acc_q[W-1:1])}) && (c_q == $past(acc_q[0])) && $stable(z_q)); // R7
  AST_CLF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok && op_code == OPC_CLF |=> !c_q && !z_q && $stable(acc_q)); // R8
  AST_DCLR_ONLY_ON_CLF: assert property (@(posedge clk) disable iff (!rst_n)
    res_d_clr |-> acc_ok && op_code == OPC_CLF); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ok |=> $stable(acc_q) && $stable(c_q) && $stable(z_q)); // R9
  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> op_ready); // R1
endmodule

bind acc_alu_core acc_alu_checker #(.W(W)) u_acc_alu_checker (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_code(op_code), .operand(operand), .acc_q(acc_q), .c_q(c_q),
  .z_q(z_q), .res_d_clr(res_d_clr)
);

// File: tb/test_acc_alu_core.sv
module test_acc_alu_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [3:0] op_code = 4'h0;
  logic [7:0] operand = 8'h00;
  logic [7:0] res_acc;
  logic       res_acc_we, res_c, res_c_we, res_z, res_z_we, res_d_clr;
  logic [7:0] acc_q;
  logic       c_q, z_q;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_acc;
  logic       m_c, m_z;

  acc_alu_core #(.W(8)) i_acc_alu_core (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .operand(operand), .res_acc(res_acc), .res_acc_we(res_acc_we),
    .res_c(res_c), .res_c_we(res_c_we), .res_z(res_z), .res_z_we(res_z_we),
    .res_d_clr(res_d_clr), .acc_q(acc_q), .c_q(c_q), .z_q(z_q)
  );

  always #4 clk = ~clk;

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h5, 4'h6: return "R2";
      4'h7:       return "R3";
      4'h8:       return "R4";
      4'hA:       return "R5";
      4'hD:       return "R6";
      4'hE:       return "R7";
      4'hF:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [7:0] b);
    logic [8:0] t;
    logic       we_exp;
    op_valid = 1'b1;
    op_code  = op;
    operand  = b;
    #1;
    we_exp = (op inside {4'h5, 4'h6, 4'h7, 4'h8, 4'hD, 4'hE});
    check(tag_of(op), "res_acc_we", res_acc_we, we_exp);
    check("R8", "res_d_clr", res_d_clr, op == 4'hF);
    case (op)
      4'h5: begin m_acc = m_acc & b; m_z = (m_acc == 0); end
      4'h6: begin m_acc = m_acc | b; m_z = (m_acc == 0); end
      4'h7: begin t = {1'b0, m_acc} + {1'b0, b}; m_acc = t[7:0]; m_c = t[8]; m_z = (m_acc == 0); end
      4'h8: begin m_c = (b > m_acc); m_acc = m_acc - b; m_z = (m_acc == 0); end
      4'hA: begin m_c = (b > m_acc); m_z = (m_acc == b); end
      4'hD: {m_c, m_acc} = {m_acc, m_c};
      4'hE: {m_acc, m_c} = {m_c, m_acc};
      4'hF: begin m_c = 1'b0; m_z = 1'b0; end
      default: ;
    endcase
    // R10: registered state shows the update one clock after acceptance
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check(tag_of(op), "acc_q", acc_q, m_acc);
    check(tag_of(op), "c_q", c_q, m_c);
    check(tag_of(op), "z_q", z_q, m_z);
  endtask

  task automatic idle_cycle();
    op_valid = 1'b0;
    op_code  = 4'h7;
    operand  = 8'h01;
    #1;
    check("R9", "res enables idle", {res_acc_we, res_c_we, res_z_we}, 0);
    @(posedge clk);
    @(negedge clk);
    check("R9", "acc_q idle", acc_q, m_acc);
    check("R9", "c_q idle", c_q, m_c);
    check("R9", "z_q idle", z_q, m_z);
  endtask

  task automatic set_state(input logic [7:0] a, input logic c);
    do_op(4'h5, 8'h00);
    if (c) begin
      do_op(4'h6, 8'hFF);
      do_op(4'h7, 8'h01);
    end else begin
      do_op(4'hF, 8'h00);
    end
    do_op(4'h6, a);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_acc = 8'h00; m_c = 1'b0; m_z = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "op_ready in reset", op_ready, 0);
    check("R1", "acc_q in reset", acc_q, 0);
    check("R1", "flags in reset", {c_q, z_q}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "op_ready after reset", op_ready, 1);

    // directed: carry and zero in the same cycle
    set_state(8'h80, 1'b0); do_op(4'h7, 8'h80);
    set_state(8'hFF, 1'b0); do_op(4'h7, 8'h01);
    set_state(8'h42, 1'b1); do_op(4'h8, 8'h42);
    set_state(8'h41, 1'b0); do_op(4'hA, 8'h42);
    set_state(8'h81, 1'b0); do_op(4'hD, 8'h00); do_op(4'hD, 8'h00); do_op(4'hE, 8'h00);
    idle_cycle();

    // sweep over accumulator, carry, opcode and operand
    for (int a = 0; a < 256; a += 15) begin
      for (int c = 0; c < 2; c++) begin
        for (int op = 0; op < 16; op++) begin
          for (int b = 0; b < 256; b += 15) begin
            set_state(a[7:0], c[0]);
            do_op(op[3:0], b[7:0]);
          end
        end
        idle_cycle();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule